// File: doc/BRIEF.md
# Polyphase 5/4 Rational Resampler

This block raises the sample rate of a stream by 5/4: for every four samples it takes in, it emits five. The filter is a prototype low-pass FIR split into five polyphase branches. Each output is computed only from the branch that matches the current output phase, so no multiplications are spent on the zeros that upsampling by five would insert. The whole branch is evaluated in one cycle with one multiplier per tap.

A phase index steps by four (modulo five) after every output. When the step wraps past five, one new input sample must be shifted into the tap history before the next output. The resulting phase order is 0, 4, 3, 2, 1, which repeats every five outputs and uses four inputs. Output is limited to one sample per clock, so the long-term input rate must stay at or below 0.8 samples per clock. Input can arrive in bursts. A small FIFO absorbs each burst, and its depth must cover the burst length minus the samples consumed while the burst lasts.

The input side is a valid/ready stream. A sample transfers on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` depends only on FIFO occupancy, never on `in_valid`, and falls only when the FIFO is full, so a source that holds its sample while `in_ready` is low loses nothing. The output side is qualified by valid alone and has no back-pressure. The block emits at most one sample per clock.

Top module: `rsmp_resampler`

## Requirements
- R1: `in_ready` is high whenever the input FIFO (DEPTH entries, default 4) holds fewer than DEPTH samples and low when it is full. Every sample offered with `in_valid` while `in_ready` is high is used exactly once, in arrival order.
- R2: Output number j (counted from 0 after reset) uses input index n = floor(4j/5) and phase p = (4j) mod 5. Its value is y = sum over k = 0..NTAP-1 of h[5k+p]·x[n-k], where x is the accepted input sequence and x at a negative index is 0.
- R3: The sum is rounded by adding 2^(SHIFT-1) and then arithmetically shifting right by SHIFT (default 14).
- R4: The rounded result saturates to the signed OW-bit range (default 16 bits, -32768..32767).
- R5: The phase sequence is 0, 4, 3, 2, 1 and repeats. A new input is shifted into the tap history after every output except one at phase 0.
- R6: When the next output needs a new input and the FIFO is empty, no output is emitted. After m inputs and an idle period, exactly ceil(5m/4) outputs have appeared.
- R7: `out_valid` pulses at most once per clock. While the FIFO never runs empty, `out_valid` is high on every cycle.
- R8: Synchronous reset (`rst` high) clears the tap history, empties the FIFO, sets the phase to 0 and holds `out_valid` low. The first output after reset uses branch 0 on the first accepted input.
- R9: The prototype coefficient is h[i] = (i+1)·(5·NTAP−i)·SCALE for i = 0..5·NTAP−1, with defaults NTAP = 4 and SCALE = 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | FIFO can take a sample this cycle |
| in_data | input | DW (16) | Signed input sample |
| out_valid | output | 1 | Output sample present this cycle |
| out_data | output | OW (16) | Signed, rounded, saturated output sample |

## Verification
The hardest case to reach is the one where the phase walk, the stall on an empty FIFO and a full FIFO all act on the same stream. A single impulse from reset exercises only a few phase/tap pairs. The bench therefore repeats the impulse at five alignments, which sweeps every coefficient through every branch and checks the stall count after one, four and eight inputs. An unbroken valid stream runs faster than the 0.8 drain rate, so the FIFO fills and `in_ready` drops while outputs stay back to back. Bursty and saturating streams and a reset in mid-stream cover the remaining cases. The arithmetic is predicted from the formula, not from any phase state.

// File: rtl/rsmp_pkg.sv
package rsmp_pkg;
  // Prototype low-pass coefficient: a symmetric parabola over len taps.
  function automatic int proto_coef(input int idx, input int len, input int scale);
    return (idx + 1) * (len - idx) * scale;
  endfunction
endpackage

// File: rtl/rsmp_fifo.sv
module rsmp_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CNTW-1:0] level,
  output logic          full,
  output logic          empty
);
  localparam logic [AW-1:0]   LAST = AW'(DEPTH - 1);
  localparam logic [CNTW-1:0] CAP  = CNTW'(DEPTH);

  logic [DW-1:0] store [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  assign full  = (level == CAP);
  assign empty = (level == '0);
  assign head  = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/rsmp_ctrl.sv
module rsmp_ctrl #(
  parameter int L  = 5,
  parameter int M  = 4,
  localparam int PW = $clog2(L),
  localparam int SW = $clog2(L + M)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          have_data,
  output logic          fire,
  output logic          take,
  output logic          need,
  output logic [PW-1:0] phase
);
  logic [SW-1:0] stepped;
  logic          wrap;

  assign stepped = SW'(phase) + SW'(M);
  assign wrap    = (stepped >= SW'(L));
  assign fire    = !need || have_data;
  assign take    = fire && need;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      need  <= 1'b1;
    end else if (fire) begin
      need  <= wrap;
      phase <= wrap ? PW'(stepped - SW'(L)) : PW'(stepped);
    end
  end
endmodule

// File: rtl/rsmp_mac.sv
module rsmp_mac #(
  parameter int DW    = 16,
  parameter int OW    = 16,
  parameter int CW    = 16,
  parameter int NTAP  = 4,
  parameter int L     = 5,
  parameter int SCALE = 64,
  parameter int SHIFT = 14,
  localparam int PW   = $clog2(L),
  localparam int PRW  = DW + CW,
  localparam int ACCW = DW + CW + $clog2(NTAP) + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fire,
  input  logic                 take,
  input  logic signed [DW-1:0] fresh,
  input  logic [PW-1:0]        phase,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_data
);
  localparam logic signed [ACCW-1:0] HALF = ACCW'(longint'(1) <<< (SHIFT - 1));
  localparam logic signed [ACCW-1:0] OMAX = ACCW'((longint'(1) <<< (OW - 1)) - 1);
  localparam logic signed [ACCW-1:0] OMIN = ACCW'(-(longint'(1) <<< (OW - 1)));

  logic signed [CW-1:0]  coef_tab [L][NTAP];
  logic signed [DW-1:0]  hist [NTAP];
  logic signed [DW-1:0]  tap  [NTAP];
  logic signed [PRW-1:0] prod [NTAP];
  logic signed [ACCW-1:0] acc, rounded, scaled, clipped;

  for (genvar p = 0; p < L; p++) begin : g_ph
    for (genvar k = 0; k < NTAP; k++) begin : g_tp
      localparam int CV = rsmp_pkg::proto_coef(k * L + p, L * NTAP, SCALE);
      assign coef_tab[p][k] = CW'(CV);
    end
  end

  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    if (k == 0) begin : g_head
      assign tap[k] = take ? fresh : hist[k];
    end else begin : g_rest
      assign tap[k] = take ? hist[k-1] : hist[k];
    end
    assign prod[k] = PRW'(tap[k]) * PRW'(coef_tab[phase][k]);
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < NTAP; k++) acc = acc + ACCW'(prod[k]);
    rounded = acc + HALF;
    scaled  = rounded >>> SHIFT;
    if (scaled > OMAX)      clipped = OMAX;
    else if (scaled < OMIN) clipped = OMIN;
    else                    clipped = scaled;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      for (int k = 0; k < NTAP; k++) hist[k] <= '0;
    end else begin
      out_valid <= fire;
      if (fire) begin
        out_data <= OW'(clipped);
        for (int k = 0; k < NTAP; k++) hist[k] <= tap[k];
      end
    end
  end
endmodule

// File: rtl/rsmp_resampler.sv
module rsmp_resampler #(
  parameter int DW    = 16,
  parameter int OW    = 16,
  parameter int CW    = 16,
  parameter int NTAP  = 4,
  parameter int L     = 5,
  parameter int M     = 4,
  parameter int DEPTH = 4,
  parameter int SCALE = 64,
  parameter int SHIFT = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [OW-1:0] out_data
);
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam int PW   = $clog2(L);

  logic [CNTW-1:0] fifo_cnt;
  logic [DW-1:0]   head;
  logic            full, empty;
  logic            fire, take, need;
  logic [PW-1:0]   phase;

  assign in_ready = !full;

  rsmp_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .push(in_valid && in_ready), .push_data(in_data),
    .pop(take), .head(head),
    .level(fifo_cnt), .full(full), .empty(empty)
  );

  rsmp_ctrl #(.L(L), .M(M)) u_ctrl (
    .clk(clk), .rst(rst), .have_data(!empty),
    .fire(fire), .take(take), .need(need), .phase(phase)
  );

  rsmp_mac #(
    .DW(DW), .OW(OW), .CW(CW), .NTAP(NTAP), .L(L),
    .SCALE(SCALE), .SHIFT(SHIFT)
  ) u_mac (
    .clk(clk), .rst(rst), .fire(fire), .take(take),
    .fresh(head), .phase(phase),
    .out_valid(out_valid), .out_data(out_data)
  );
endmodule

// File: rtl/rsmp_resampler_chk.sv
module rsmp_resampler_chk #(
  parameter int DEPTH = 4,
  parameter int L     = 5,
  parameter int CNTW  = 3,
  parameter int PW    = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic [CNTW-1:0] fifo_cnt,
  input logic            need,
  input logic            fire,
  input logic            take,
  input logic [PW-1:0]   phase
);
  // R1
  fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_cnt <= CNTW'(DEPTH));

  // R1
  fifo_push_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !take) |=> fifo_cnt == $past(fifo_cnt) + 1'b1);

  // R5
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    phase < PW'(L));

  // R5
  phase_zero_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && phase == '0) |=> !need);

  // R6
  stall_chk: assert property (@(posedge clk) disable iff (rst)
    (need && fifo_cnt == '0) |=> !out_valid);

  // R7
  fire_out_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> out_valid);

  // R8
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_valid && fifo_cnt == '0 && phase == '0 && need));
endmodule

bind rsmp_resampler rsmp_resampler_chk #(
  .DEPTH(DEPTH), .L(L), .CNTW(CNTW), .PW(PW)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .fifo_cnt(fifo_cnt), .need(need),
  .fire(fire), .take(take), .phase(phase)
);

// File: tb/rsmp_resampler_bench.sv
module rsmp_resampler_bench;
  localparam int PERIOD = 10;
  localparam int DW = 16, OW = 16, NTAP = 4, L = 5, M = 4;
  localparam int SCALE = 64, SHIFT = 14;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic in_ready, out_valid;
  logic signed [DW-1:0] in_data = '0;
  logic signed [OW-1:0] out_data;

  int n_chk = 0, n_bad = 0, nout = 0;
  int xs[$];
  bit last_acc, saw_full, win;
  int win_cyc, win_val, seen_max, seen_min;
  string tag = "R2";
  logic [15:0] lfsr = 16'hACE1;

  always #(PERIOD/2) clk = ~clk;

  rsmp_resampler u_rsmp_resampler (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_out(input int j);
    longint acc = 0;
    int n = (M * j) / L;
    int ph = (M * j) % L;
    for (int k = 0; k < NTAP; k++) begin
      int idx = n - k;
      int mi = k * L + ph;
      if (idx >= 0 && idx < xs.size())
        acc += longint'(xs[idx]) * longint'((mi + 1) * (L * NTAP - mi) * SCALE);
    end
    acc = (acc + (longint'(1) <<< (SHIFT - 1))) >>> SHIFT;   // R3
    if (acc > 32767) acc = 32767;                            // R4
    if (acc < -32768) acc = -32768;
    return int'(acc);
  endfunction

  function automatic logic [15:0] next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr;
  endfunction

  task automatic step(input bit v, input logic signed [DW-1:0] d);
    @(negedge clk);
    if (out_valid) begin
      int exp = model_out(nout);
      check(int'(out_data) == exp, tag, int'(out_data), exp);
      if (int'(out_data) == 32767) seen_max++;
      if (int'(out_data) == -32768) seen_min++;
      nout++;
    end
    if (win) begin
      win_cyc++;
      if (out_valid) win_val++;
    end
    in_valid = v;
    in_data  = d;
    #1;
    last_acc = v && in_ready;
    if (v && !in_ready) saw_full = 1'b1;
    if (last_acc) xs.push_back(int'(d));
  endtask

  // mode 0: every cycle random, 1: bursty random, 2: constant cval
  task automatic stream(input int cnt, input int mode, input int cval);
    int sent = 0;
    int cyc = 0;
    logic signed [DW-1:0] cur;
    cur = (mode == 2) ? DW'(cval) : next_rand();
    while (sent < cnt) begin
      bit v = (mode != 1) || (((cyc / 6) % 3) != 2);
      step(v, cur);
      cyc++;
      if (last_acc) begin
        sent++;
        cur = (mode == 2) ? DW'(cval) : next_rand();
      end
    end
  endtask

  task automatic drain(input int n);
    repeat (n) step(1'b0, '0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    xs.delete();
    nout = 0;
  endtask

  task automatic rate_check(input string req);
    int m = xs.size();
    check(nout == (5 * m + 3) / 4, req, nout, (5 * m + 3) / 4);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(PERIOD * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R8 reset state seen at the ports
    check(out_valid == 1'b0, "R8 out_valid", int'(out_valid), 0);
    check(in_ready == 1'b1, "R8 in_ready", int'(in_ready), 1);

    // Impulse at five alignments: sweeps every coefficient through each branch
    for (int off = 0; off < 5; off++) begin
      tag = "R5/R9 impulse";
      do_reset();
      if (off > 0) stream(off, 2, 0);
      stream(1, 2, 1000);
      drain(12);
      if (off == 0) check(nout == 2, "R6 stall after one input", nout, 2);
      stream(3, 2, 0);
      drain(12);
      if (off == 0) check(nout == 5, "R6 stall after four inputs", nout, 5);
      stream(4, 2, 0);
      drain(12);
      rate_check("R6 impulse count");
    end

    // R1, R7: unbroken source outruns the 0.8 drain rate
    tag = "R2/R3 continuous";
    do_reset();
    saw_full = 1'b0;
    stream(20, 0, 0);
    win = 1'b1; win_cyc = 0; win_val = 0;
    stream(200, 0, 0);
    win = 1'b0;
    check(saw_full, "R1 in_ready low when full", int'(saw_full), 1);
    check(win_val == win_cyc, "R7 back-to-back outputs", win_val, win_cyc);
    drain(20);
    rate_check("R1/R6 continuous count");

    // Bursty source
    tag = "R2/R3 bursty";
    stream(150, 1, 0);
    drain(20);
    rate_check("R1/R6 bursty count");

    // R4 saturation at both rails
    tag = "R4 saturation";
    do_reset();
    seen_max = 0; seen_min = 0;
    stream(16, 2, 32767);
    stream(16, 2, -32768);
    drain(20);
    check(seen_max > 0, "R4 positive clip", seen_max, 1);
    check(seen_min > 0, "R4 negative clip", seen_min, 1);
    rate_check("R6 saturation count");

    // R8: reset in the middle of a stream, then restart from branch 0
    tag = "R2 pre-reset";
    stream(7, 0, 0);
    do_reset();
    @(negedge clk);
    check(out_valid == 1'b0, "R8 out_valid after mid reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R8 fifo empty after mid reset", int'(in_ready), 1);
    tag = "R8 restart";
    stream(1, 2, 1000);
    stream(5, 2, 0);
    drain(12);
    rate_check("R8 restart count");

    finish_run();
  end
endmodule